// File: doc/BRIEF.md
# Vehicle Gate Open/Close Sequencer

This block runs one barrier gate, at either the entrance or the exit of a car park. It reads two beam-break lines from a pair of spaced optical detectors. A line is high while its light path is blocked. A vehicle is recognised only when both lines are high together. One beam on its own, such as a person walking through, never starts a cycle. Both inputs are resynchronised to the system clock. The coincidence must then persist for a programmable number of 1 ms ticks before it counts as a valid trigger.

A valid trigger, accepted while the enable input is high, starts a timed cycle. The motor drives the gate open, then rests for a programmable dwell, then drives the gate closed. The dwell is typically set to 10000 ticks, which is 10 s. Each of the three phases has its own tick count. The motor is driven by two active-high lines: one turns it clockwise (open) and the other anticlockwise (close). The block never raises both lines together. After the close phase ends, a one-cycle done pulse is issued, which an external vehicle counter consumes. An occupancy monitor can hold the enable low to refuse new entries while the park is full.

Top module: `gate_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, mot_open_o, mot_close_o and done_o are all low.
- R2: If the two beam inputs are never high at the same time, no cycle starts, whatever the pattern of single-beam activity (mot_open_o stays low).
- R3: A coincidence must remain present for at least hold_ticks_i ticks after synchronisation before it triggers. A shorter coincidence starts nothing. A held coincidence starts the open phase within 3 + (hold_ticks_i+1)*CLK_PER_TICK cycles.
- R4: A cycle is always ordered as open drive (mot_open_o high), then dwell (both lines low), then close drive (mot_close_o high). mot_open_o and mot_close_o are never high together.
- R5: Each phase with a programmed count N ends on the max(N,1)-th tick seen in that phase. Its length in cycles therefore lies in [(M-1)*CLK_PER_TICK+1, M*CLK_PER_TICK], where M = max(N,1). One tick is produced every CLK_PER_TICK clock cycles.
- R6: done_o is high for exactly one cycle. That cycle is the first one after mot_close_o falls. done_o is never high at any other time.
- R7: No cycle starts while en_i is low. A coincidence that qualifies while en_i is low, or while a cycle is running, is discarded. The beams must clear before a new trigger can occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Entry permit from the occupancy monitor |
| beam_a_i | input | 1 | First beam-break line, high when blocked |
| beam_b_i | input | 1 | Second beam-break line, high when blocked |
| hold_ticks_i | input | TW | Ticks the coincidence must persist |
| open_ticks_i | input | TW | Open-drive length in ticks |
| dwell_ticks_i | input | TW | Dwell length in ticks |
| close_ticks_i | input | TW | Close-drive length in ticks |
| mot_open_o | output | 1 | Motor clockwise (open) drive |
| mot_close_o | output | 1 | Motor anticlockwise (close) drive |
| done_o | output | 1 | One-cycle pulse after the close phase |

## Verification
The assertions check on every cycle that the motor lines are never high together. They also check that open, dwell and close follow one another in that order, that each done pulse is a single cycle directly following the close drive, and that no open begins unless the enable was high. Only the bench scenarios can show the timing side. These scenarios cover phase lengths against programmed counts, including a zero count. They also cover rejection of single-beam and too-short coincidences, and the discarding of a trigger that qualified while disabled or busy.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_DWELL = 2'd2,
    ST_CLOSE = 2'd3
  } gate_state_e;
endpackage

// File: rtl/gate_tick_gen.sv
module gate_tick_gen #(
  parameter int unsigned CLK_PER_TICK = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/gate_beam_qual.sv
module gate_beam_qual #(
  parameter int unsigned NB = 2,
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] beams_i,
  input  logic          tick_i,
  input  logic [TW-1:0] hold_i,
  output logic          trig_o
);
  logic [NB-1:0] sync_all;

  for (genvar g = 0; g < NB; g++) begin : g_sync
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= beams_i[g];
        sync_q <= meta_q;
      end
    end
    assign sync_all[g] = sync_q;
  end

  logic          all_hit;
  logic          met;
  logic          fired_q;
  logic [TW-1:0] hcnt_q;

  assign all_hit = &sync_all;
  assign met     = (hcnt_q >= hold_i);
  // one trigger per coincidence; beams must clear to re-arm
  assign trig_o  = all_hit && met && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      fired_q <= 1'b0;
    end else if (!all_hit) begin
      hcnt_q  <= '0;
      fired_q <= 1'b0;
    end else begin
      if (tick_i && !met) hcnt_q <= hcnt_q + TW'(1);
      if (trig_o)         fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gate_phase_fsm.sv
module gate_phase_fsm
  import gate_seq_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          trig_i,
  input  logic          en_i,
  input  logic [TW-1:0] open_n_i,
  input  logic [TW-1:0] dwell_n_i,
  input  logic [TW-1:0] close_n_i,
  output logic          mot_open_o,
  output logic          mot_close_o,
  output logic          done_o
);
  gate_state_e   state_q;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] len;
  logic [TW:0]   nxt;
  logic          last;
  logic          done_q;

  always_comb begin
    case (state_q)
      ST_OPEN:  len = open_n_i;
      ST_DWELL: len = dwell_n_i;
      ST_CLOSE: len = close_n_i;
      default:  len = '0;
    endcase
  end

  // count of zero behaves as one tick
  assign nxt  = {1'b0, tmr_q} + (TW+1)'(1);
  assign last = tick_i && (nxt >= {1'b0, len});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (trig_i && en_i) state_q <= ST_OPEN;
        end
        ST_OPEN, ST_DWELL, ST_CLOSE: begin
          if (last) begin
            tmr_q <= '0;
            case (state_q)
              ST_OPEN:  state_q <= ST_DWELL;
              ST_DWELL: state_q <= ST_CLOSE;
              default: begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            endcase
          end else if (tick_i) begin
            tmr_q <= nxt[TW-1:0];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mot_open_o  = (state_q == ST_OPEN);
  assign mot_close_o = (state_q == ST_CLOSE);
  assign done_o      = done_q;
endmodule

// File: rtl/gate_seq.sv
module gate_seq #(
  parameter int unsigned CLK_PER_TICK = 100000,
  parameter int unsigned TW           = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          beam_a_i,
  input  logic          beam_b_i,
  input  logic [TW-1:0] hold_ticks_i,
  input  logic [TW-1:0] open_ticks_i,
  input  logic [TW-1:0] dwell_ticks_i,
  input  logic [TW-1:0] close_ticks_i,
  output logic          mot_open_o,
  output logic          mot_close_o,
  output logic          done_o
);
  logic tick;
  logic trig;

  gate_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  gate_beam_qual #(.NB(2), .TW(TW)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .beams_i ({beam_b_i, beam_a_i}),
    .tick_i  (tick),
    .hold_i  (hold_ticks_i),
    .trig_o  (trig)
  );

  gate_phase_fsm #(.TW(TW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .trig_i      (trig),
    .en_i        (en_i),
    .open_n_i    (open_ticks_i),
    .dwell_n_i   (dwell_ticks_i),
    .close_n_i   (close_ticks_i),
    .mot_open_o  (mot_open_o),
    .mot_close_o (mot_close_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic mot_open_o,
  input logic mot_close_o,
  input logic done_o
);
  a_r4_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mot_open_o && mot_close_o));

  a_r4_dwell_follows_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mot_open_o) |-> !mot_close_o);

  a_r4_close_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mot_close_o) |-> $past(!mot_open_o && !mot_close_o));

  a_r6_done_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mot_close_o) && !mot_close_o && !mot_open_o));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_open_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mot_open_o) |-> $past(en_i));
endmodule

bind gate_seq gate_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .mot_open_o  (mot_open_o),
  .mot_close_o (mot_close_o),
  .done_o      (done_o)
);

// File: tb/gate_seq_test.sv
module gate_seq_test;
  localparam int P  = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, beam_a_i = 1'b0, beam_b_i = 1'b0;
  logic [TW-1:0] hold_ticks_i = '0, open_ticks_i = 8'd1, dwell_ticks_i = 8'd1, close_ticks_i = 8'd1;
  logic mot_open_o, mot_close_o, done_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  gate_seq #(.CLK_PER_TICK(P), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .beam_a_i(beam_a_i), .beam_b_i(beam_b_i),
    .hold_ticks_i(hold_ticks_i), .open_ticks_i(open_ticks_i),
    .dwell_ticks_i(dwell_ticks_i), .close_ticks_i(close_ticks_i),
    .mot_open_o(mot_open_o), .mot_close_o(mot_close_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction
  function automatic int lo_len(input int n);
    return (eff(n) - 1) * P + 1;
  endfunction
  function automatic int hi_len(input int n);
    return eff(n) * P;
  endfunction

  // observe N cycles; returns 1 if any motor line was seen high
  task automatic watch_idle(input int n, output bit moved);
    moved = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mot_open_o || mot_close_o) moved = 1;
    end
  endtask

  task automatic run_cycle(input int o, input int d, input int c, input int h);
    int t = 0, ph = 0, on = 0, dw = 0, cn = 0, start_t = 0;
    bit both = 0, early_done = 0, done_ok = 0, moved;
    open_ticks_i = TW'(o); dwell_ticks_i = TW'(d);
    close_ticks_i = TW'(c); hold_ticks_i = TW'(h);
    en_i = 1'b1;
    @(negedge clk);
    beam_a_i = 1'b1; beam_b_i = 1'b1;
    while (ph < 4 && t < 3000) begin
      @(negedge clk);
      t++;
      if (mot_open_o && mot_close_o) both = 1;
      if (done_o && ph < 3) early_done = 1;
      case (ph)
        0: if (mot_open_o) begin ph = 1; on = 1; start_t = t; end
        1: if (mot_open_o) on++; else if (!mot_close_o) begin ph = 2; dw = 1; end else ph = 9;
        2: if (mot_close_o) begin ph = 3; cn = 1; end else if (mot_open_o) ph = 9; else dw++;
        3: if (mot_close_o) cn++; else begin ph = 4; done_ok = done_o; end
        default: ;
      endcase
    end
    chk(ph == 4, "R4 cycle order open-dwell-close", ph, 4);
    chk(!both, "R4 both motor lines high", int'(both), 0);
    chk(start_t <= 3 + (h + 1) * P + 1, "R3 start latency", start_t, 3 + (h + 1) * P + 1);
    chk(on >= lo_len(o) && on <= hi_len(o), "R5 open length", on, hi_len(o));
    chk(dw >= lo_len(d) && dw <= hi_len(d), "R5 dwell length", dw, hi_len(d));
    chk(cn >= lo_len(c) && cn <= hi_len(c), "R5 close length", cn, hi_len(c));
    chk(done_ok && !early_done, "R6 done after close", int'(done_ok), 1);
    @(negedge clk);
    chk(!done_o, "R6 done single cycle", int'(done_o), 0);
    // beams still blocked: no re-trigger (R7)
    watch_idle(4 * P + 8, moved);
    chk(!moved, "R7 held beams re-trigger", int'(moved), 0);
    beam_a_i = 1'b0; beam_b_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit moved;
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!mot_open_o && !mot_close_o && !done_o, "R1 in reset", int'({mot_open_o, mot_close_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!mot_open_o && !mot_close_o && !done_o, "R1 after release", int'({mot_open_o, mot_close_o, done_o}), 0);

    // R2 single beams, alternating, never together
    en_i = 1'b1; hold_ticks_i = 8'd0;
    beam_a_i = 1'b1;
    watch_idle(30, moved);
    chk(!moved, "R2 beam a only", int'(moved), 0);
    beam_a_i = 1'b0; @(negedge clk); beam_b_i = 1'b1;
    watch_idle(30, moved);
    chk(!moved, "R2 beam b only", int'(moved), 0);
    for (int i = 0; i < 10; i++) begin
      beam_a_i = ~beam_b_i ? 1'b0 : 1'b0;
      beam_b_i = 1'b0; beam_a_i = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      beam_a_i = 1'b0; beam_b_i = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
    end
    beam_b_i = 1'b0;
    watch_idle(10, moved);
    chk(!moved, "R2 alternating beams", int'(moved), 0);

    // R3 coincidence shorter than hold
    hold_ticks_i = 8'd3;
    beam_a_i = 1'b1; beam_b_i = 1'b1;
    repeat (2 * P) @(negedge clk);
    beam_a_i = 1'b0; beam_b_i = 1'b0;
    watch_idle(6 * P, moved);
    chk(!moved, "R3 short coincidence", int'(moved), 0);

    // R7 disabled: no start, and consumed trigger does not fire on enable
    en_i = 1'b0; hold_ticks_i = 8'd1;
    beam_a_i = 1'b1; beam_b_i = 1'b1;
    watch_idle(60, moved);
    chk(!moved, "R7 disabled no start", int'(moved), 0);
    en_i = 1'b1;
    watch_idle(40, moved);
    chk(!moved, "R7 discarded while disabled", int'(moved), 0);
    beam_a_i = 1'b0; beam_b_i = 1'b0;
    repeat (4) @(negedge clk);

    // directed corners, including zero counts (R5)
    run_cycle(0, 0, 0, 0);
    run_cycle(1, 2, 1, 1);
    run_cycle(5, 0, 3, 2);

    // random
    for (int i = 0; i < 8; i++)
      run_cycle(int'($urandom_range(0, 5)), int'($urandom_range(0, 6)),
                int'($urandom_range(0, 5)), int'($urandom_range(0, 3)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule